// File: doc/BRIEF.md
# Gapped Serial Test-Pattern Transmitter

This block generates a bit-error-rate test stream and puts it onto an outgoing serial line in place of normal traffic. The stream is one of three pseudo-random sequences, a quasi-random variant with a limit on zero runs, or a user word of 1 to 32 bits that is sent again and again. A line-side clock enable marks the cycles in which one bit may leave. In every other cycle the generator and its output stay where they are, so a gapped enable can confine the pattern to selected channel slots.

While the generator is switched off, the normal serial data bit is copied to the output on every enabled cycle, and all sequences sit at their seed. When the generator is switched on it takes over the line and starts every sequence from that seed. A one-cycle strobe inverts exactly one outgoing pattern bit. If no bit leaves in the strobe cycle, the request waits for the next bit that does.

Top module: `bert_tx_gen`

## Requirements
- R1: While `rst_n` is low, `line_dout` and `line_dout_vld` are 0.
- R2: `line_dout_vld` is 1 in exactly the cycles that follow a cycle with `bit_en` high, and one bit is emitted per such cycle. In the cycle after `bit_en` is low, `line_dout` keeps its value and no generator state changes, so gaps never alter the emitted sequence.
- R3: With `gen_en` low, a cycle with `bit_en` high makes `line_dout` equal that cycle's `line_din` in the next cycle.
- R4: `pat_sel` 0, 1 and 2 select pseudo-random sequences of length 9, 15 and 23 with feedback taps 5, 14 and 18. Each emitted bit is fb = s[L-1] xor s[T-1], and the register shifts left with fb entering bit 0. Every register holds all ones while `gen_en` is low.
- R5: `pat_sel` 3 selects a quasi-random stream built on a length-20 register with tap 17 (same rule as R4). When 14 zero pattern bits have just been emitted, the next pattern bit is forced to 1, so a run never exceeds 14 zeros. The count ignores inserted errors.
- R6: `pat_sel` 4 (and 5 to 7) sends `rep_word` least significant bit first over n = `rep_len`+1 bits (1 to 32), then wraps to bit 0.
- R7: Lowering `gen_en` for one or more cycles and raising it again restarts every sequence and the word position from its first bit.
- R8: An `err_ins` strobe in a cycle with `gen_en` and `bit_en` high inverts that cycle's emitted bit and no other bit.
- R9: An `err_ins` strobe with `gen_en` high and `bit_en` low is held and inverts the next emitted bit only. Several strobes before that bit still invert a single bit.
- R10: `err_ins` has no effect while `gen_en` is low: bypass data is unchanged, and no held request survives into the next enabled period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gen_en | input | 1 | 1: generator owns the line; 0: normal data passes |
| bit_en | input | 1 | Gapped line enable, one bit per high cycle |
| pat_sel | input | 3 | Pattern select (0 PN9, 1 PN15, 2 PN23, 3 quasi-random, 4-7 word) |
| rep_word | input | WORD_W | Repeating pattern word |
| rep_len | input | LEN_W | Repeating length minus one |
| err_ins | input | 1 | Single-error insert strobe |
| line_din | input | 1 | Normal outgoing serial data |
| line_dout | output | 1 | Serial line output |
| line_dout_vld | output | 1 | High for one cycle when a new bit is on `line_dout` |

## Verification
Error insertion can land in the same cycle as other bit-level decisions, and those collisions are where mistakes hide. A strobe that arrives with an enabled bit while a held request is already waiting must still flip only one bit. A strobe placed on the exact bit where the quasi-random zero limit forces a 1 must emit 0 and must leave the zero-run count untouched. The bench works out in advance, from its own model, which bit the first forced 1 falls on, injects the strobe there, and compares every emitted bit with the model's inverted value. It also compares the clean bits that follow.

// File: rtl/bert_pkg.sv
// Shared constants for the test-pattern transmitter.
// Assumes pattern select codes above PSEL_WORD behave as PSEL_WORD.
package bert_pkg;

    localparam logic [2:0] PSEL_PN9  = 3'd0;
    localparam logic [2:0] PSEL_PN15 = 3'd1;
    localparam logic [2:0] PSEL_PN23 = 3'd2;
    localparam logic [2:0] PSEL_QRSS = 3'd3;
    localparam logic [2:0] PSEL_WORD = 3'd4;

    localparam int PN_CNT    = 3;
    localparam int QRSS_LEN  = 20;
    localparam int QRSS_TAP  = 17;

    // Register length of pseudo-random generator number idx.
    function automatic int pn_len(input int idx);
        case (idx)
            0:       return 9;
            1:       return 15;
            default: return 23;
        endcase
    endfunction

    // Second feedback tap of pseudo-random generator number idx.
    function automatic int pn_tap(input int idx);
        case (idx)
            0:       return 5;
            1:       return 14;
            default: return 18;
        endcase
    endfunction

endpackage

// File: rtl/bert_lfsr.sv
// Fibonacci shift register, two feedback taps, all-ones seed.
// Emits fb = s[LEN-1]^s[TAP-1] and shifts fb into bit 0 on each advance.
// Assumes reseed and adv are never both needed: reseed wins.
module bert_lfsr #(
    parameter int LEN = 9,
    parameter int TAP = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reseed,
    input  logic adv,
    output logic fb_bit
);

    logic [LEN-1:0] sreg;

    // Feedback bit is also the emitted bit for this advance.
    assign fb_bit = sreg[LEN-1] ^ sreg[TAP-1];

    // Seed, hold or shift the register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '1;
        end else if (reseed) begin
            sreg <= '1;
        end else if (adv) begin
            sreg <= {sreg[LEN-2:0], fb_bit};
        end
    end

endmodule

// File: rtl/bert_qrss_limit.sv
// Zero-run limiter for the quasi-random stream.
// Forces the bit to 1 once ZMAX zeros have been emitted back to back.
// Assumes adv marks each emitted bit; reseed clears the run count.
module bert_qrss_limit #(
    parameter int ZMAX = 14,
    localparam int ZW = $clog2(ZMAX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reseed,
    input  logic adv,
    input  logic raw_bit,
    output logic out_bit
);

    logic [ZW-1:0] zrun;

    // Force a one when the run has reached its limit.
    assign out_bit = (int'(zrun) == ZMAX) ? 1'b1 : raw_bit;

    // Track the current run of emitted zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zrun <= '0;
        end else if (reseed) begin
            zrun <= '0;
        end else if (adv) begin
            zrun <= out_bit ? '0 : zrun + 1'b1;
        end
    end

endmodule

// File: rtl/bert_word_seq.sv
// Repeating-word serializer: sends word bits 0..len_m1, then wraps.
// Assumes len_m1 may change at any time; a position past it wraps at once.
module bert_word_seq #(
    parameter int WORD_W = 32,
    localparam int LEN_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reseed,
    input  logic              adv,
    input  logic [WORD_W-1:0] word,
    input  logic [LEN_W-1:0]  len_m1,
    output logic              out_bit
);

    logic [LEN_W-1:0] pos;

    // Current word bit.
    assign out_bit = word[pos];

    // Step the bit position with wrap at the programmed length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (reseed) begin
            pos <= '0;
        end else if (adv) begin
            pos <= (pos >= len_m1) ? '0 : pos + 1'b1;
        end
    end

endmodule

// File: rtl/bert_err_inject.sv
// Single-error request holder.
// A strobe flips the bit emitted in its own cycle, or the next one if no
// bit leaves then. Requests are dropped while the generator is off.
module bert_err_inject (
    input  logic clk,
    input  logic rst_n,
    input  logic gen_en,
    input  logic adv,
    input  logic err_req,
    output logic flip,
    output logic pend
);

    // Invert this bit when a request is new or waiting.
    assign flip = gen_en & adv & (pend | err_req);

    // Hold a request until a bit consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (!gen_en || adv) begin
            pend <= 1'b0;
        end else if (err_req) begin
            pend <= 1'b1;
        end
    end

endmodule

// File: rtl/bert_tx_gen.sv
// Test-pattern transmitter top level.
// Runs every pattern source in step on each gapped enable, selects one,
// applies error insertion and drives a registered line output. With the
// generator off, line data is copied through and all sources sit at seed.
// Assumes pat_sel is changed only while gen_en is low.
module bert_tx_gen
    import bert_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int QRSS_ZMAX = 14,
    localparam int LEN_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen_en,
    input  logic              bit_en,
    input  logic [2:0]        pat_sel,
    input  logic [WORD_W-1:0] rep_word,
    input  logic [LEN_W-1:0]  rep_len,
    input  logic              err_ins,
    input  logic              line_din,
    output logic              line_dout,
    output logic              line_dout_vld
);

    logic              reseed;
    logic              gen_adv;
    logic [PN_CNT-1:0] pn_bit;
    logic              qrss_raw;
    logic              qrss_bit;
    logic              word_bit;
    logic              pat_bit;
    logic              err_flip;
    logic              err_pend;

    assign reseed  = ~gen_en;
    assign gen_adv = gen_en & bit_en;

    // Pseudo-random sources, one per supported length.
    for (genvar g = 0; g < PN_CNT; g++) begin : g_pn
        bert_lfsr #(
            .LEN(pn_len(g)),
            .TAP(pn_tap(g))
        ) u_pn (
            .clk    (clk),
            .rst_n  (rst_n),
            .reseed (reseed),
            .adv    (gen_adv),
            .fb_bit (pn_bit[g])
        );
    end

    bert_lfsr #(
        .LEN(QRSS_LEN),
        .TAP(QRSS_TAP)
    ) u_qrss_src (
        .clk    (clk),
        .rst_n  (rst_n),
        .reseed (reseed),
        .adv    (gen_adv),
        .fb_bit (qrss_raw)
    );

    bert_qrss_limit #(
        .ZMAX(QRSS_ZMAX)
    ) u_qrss_lim (
        .clk     (clk),
        .rst_n   (rst_n),
        .reseed  (reseed),
        .adv     (gen_adv),
        .raw_bit (qrss_raw),
        .out_bit (qrss_bit)
    );

    bert_word_seq #(
        .WORD_W(WORD_W)
    ) u_word (
        .clk     (clk),
        .rst_n   (rst_n),
        .reseed  (reseed),
        .adv     (gen_adv),
        .word    (rep_word),
        .len_m1  (rep_len),
        .out_bit (word_bit)
    );

    bert_err_inject u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .gen_en  (gen_en),
        .adv     (bit_en),
        .err_req (err_ins),
        .flip    (err_flip),
        .pend    (err_pend)
    );

    // Pick the selected pattern source.
    always_comb begin
        case (pat_sel)
            PSEL_PN9:  pat_bit = pn_bit[0];
            PSEL_PN15: pat_bit = pn_bit[1];
            PSEL_PN23: pat_bit = pn_bit[2];
            PSEL_QRSS: pat_bit = qrss_bit;
            default:   pat_bit = word_bit;
        endcase
    end

    // Register the line output: pattern or bypass on enabled cycles only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_dout     <= 1'b0;
            line_dout_vld <= 1'b0;
        end else begin
            line_dout_vld <= bit_en;
            if (bit_en) begin
                line_dout <= gen_en ? (pat_bit ^ err_flip) : line_din;
            end
        end
    end

endmodule

// File: rtl/bert_tx_gen_chk.sv
// Property checker for the test-pattern transmitter, bound to the top.
// Watches line timing, bypass copying, error request lifetime and the
// quasi-random zero-run bound.
module bert_tx_gen_chk #(
    parameter int QRSS_ZMAX = 14
) (
    input logic       clk,
    input logic       rst_n,
    input logic       gen_en,
    input logic       bit_en,
    input logic [2:0] pat_sel,
    input logic       line_din,
    input logic       line_dout,
    input logic       line_dout_vld,
    input logic       err_pend,
    input logic       qrss_bit
);

    logic [5:0] zcount;

    // Count emitted quasi-random zeros independently of the limiter.
    always_ff @(posedge clk) begin
        if (!rst_n || !gen_en) begin
            zcount <= '0;
        end else if (bit_en) begin
            zcount <= qrss_bit ? '0 : ((zcount == 6'h3f) ? zcount : zcount + 1'b1);
        end
    end

    AST_VLD_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |=> line_dout_vld); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> (!line_dout_vld && $stable(line_dout))); // R2
    AST_BYPASS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !gen_en) |=> (line_dout == $past(line_din))); // R3
    AST_PEND_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && gen_en) |=> !err_pend); // R9
    AST_PEND_DROPPED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> !err_pend); // R10
    AST_QRSS_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_sel == 3'd3) |-> (int'(zcount) <= QRSS_ZMAX)); // R5

endmodule

bind bert_tx_gen bert_tx_gen_chk #(
    .QRSS_ZMAX(QRSS_ZMAX)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .gen_en        (gen_en),
    .bit_en        (bit_en),
    .pat_sel       (pat_sel),
    .line_din      (line_din),
    .line_dout     (line_dout),
    .line_dout_vld (line_dout_vld),
    .err_pend      (err_pend),
    .qrss_bit      (qrss_bit)
);

// File: tb/bert_tx_gen_test.sv
module bert_tx_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gen_en = 1'b0;
    logic        bit_en = 1'b0;
    logic [2:0]  pat_sel = 3'd0;
    logic [31:0] rep_word = '0;
    logic [4:0]  rep_len = '0;
    logic        err_ins = 1'b0;
    logic        line_din = 1'b0;
    logic        line_dout;
    logic        line_dout_vld;

    always #10 clk = ~clk;

    bert_tx_gen uut (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .bit_en(bit_en),
        .pat_sel(pat_sel), .rep_word(rep_word), .rep_len(rep_len),
        .err_ins(err_ins), .line_din(line_din),
        .line_dout(line_dout), .line_dout_vld(line_dout_vld)
    );

    typedef struct {
        bit    v;
        bit    d;
        string tag;
    } exp_t;

    exp_t  sb[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_tag = "R4";

    // next-cycle configuration, applied by the driver at a falling edge
    bit        nx_gen = 0;
    bit [2:0]  nx_sel = 0;
    bit [31:0] nx_word = 0;
    bit [4:0]  nx_len = 0;

    // reference model state
    bit [8:0]  m9;
    bit [14:0] m15;
    bit [22:0] m23;
    bit [19:0] m20;
    int        mz;
    int        mpos;
    bit        mpend;

    function automatic void m_seed();
        m9 = '1; m15 = '1; m23 = '1; m20 = '1; mz = 0; mpos = 0; mpend = 0;
    endfunction

    // Model one cycle; returns the bit expected on the line if emitted.
    function automatic bit m_step(bit g, bit a, bit e, bit din);
        bit f9, f15, f23, f20, q, w, p;
        if (!g) begin
            m_seed();
            return din;
        end
        if (!a) begin
            if (e) mpend = 1;
            return 1'b0;
        end
        f9  = m9[8]   ^ m9[4];   m9  = {m9[7:0], f9};
        f15 = m15[14] ^ m15[13]; m15 = {m15[13:0], f15};
        f23 = m23[22] ^ m23[17]; m23 = {m23[21:0], f23};
        f20 = m20[19] ^ m20[16]; m20 = {m20[18:0], f20};
        q = (mz == 14) ? 1'b1 : f20;
        mz = q ? 0 : mz + 1;
        w = nx_word[mpos];
        mpos = (mpos >= int'(nx_len)) ? 0 : mpos + 1;
        case (nx_sel)
            3'd0: p = f9;
            3'd1: p = f15;
            3'd2: p = f23;
            3'd3: p = q;
            default: p = w;
        endcase
        p = p ^ (mpend | e);
        mpend = 0;
        return p;
    endfunction

    // Drive one cycle and push what the line must show after the next edge.
    task automatic drive(bit a, bit e, bit din);
        exp_t x;
        bit   r;
        @(negedge clk);
        gen_en = nx_gen; pat_sel = nx_sel; rep_word = nx_word; rep_len = nx_len;
        bit_en = a; err_ins = e; line_din = din;
        r = m_step(nx_gen, a, e, din);
        x.v = a;
        x.d = r;
        x.tag = a ? cur_tag : "R2";
        sb.push_back(x);
    endtask

    // Monitor: compare line output just after each rising edge.
    bit last_d = 0;
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t x;
            bit   ed;
            x = sb.pop_front();
            ed = x.v ? x.d : last_d;
            n_cmp++;
            if (line_dout_vld !== x.v || line_dout !== ed) begin
                n_bad++;
                $display("FAIL %s: vld=%0b dout=%0b expected vld=%0b dout=%0b",
                         x.tag, line_dout_vld, line_dout, x.v, ed);
            end
            last_d = ed;
        end
    end

    // Own model: index of the first bit where the zero limit forces a 1.
    function automatic int qrss_first_force();
        bit [19:0] s = '1;
        int z = 0;
        bit f, o;
        for (int i = 0; i < (1 << 20); i++) begin
            f = s[19] ^ s[16];
            s = {s[18:0], f};
            if (z == 14 && !f) return i;
            o = (z == 14) ? 1'b1 : f;
            z = o ? 0 : z + 1;
        end
        return -1;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        int ff, nq;
        m_seed();
        // R1: outputs cleared under reset even with enables high
        bit_en = 1; gen_en = 1; line_din = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (line_dout !== 1'b0 || line_dout_vld !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: vld=%0b dout=%0b expected vld=0 dout=0", line_dout_vld, line_dout);
        end
        bit_en = 0; gen_en = 0; line_din = 0;
        @(negedge clk);
        rst_n = 1;

        // R3: bypass with gapped enables and varied data
        cur_tag = "R3"; nx_gen = 0;
        for (int i = 0; i < 40; i++) drive(i % 4 != 1, 1'b0, ((i * 7) % 5) < 2);

        // R4: PN9 continuous across more than one period
        cur_tag = "R4"; nx_sel = 3'd0; nx_gen = 1;
        for (int i = 0; i < 600; i++) drive(1'b1, 1'b0, 1'b0);
        // R2: PN15 with gaps, continuity across idle cycles
        nx_gen = 0; drive(1'b0, 1'b0, 1'b0);
        cur_tag = "R2"; nx_sel = 3'd1; nx_gen = 1;
        for (int i = 0; i < 450; i++) drive(i % 3 != 0, 1'b0, 1'b1);
        // R4: PN23
        nx_gen = 0; drive(1'b0, 1'b0, 1'b0);
        cur_tag = "R4"; nx_sel = 3'd2; nx_gen = 1;
        for (int i = 0; i < 400; i++) drive(i % 5 != 2, 1'b0, 1'b0);

        // R7: restart after a short disable
        cur_tag = "R7"; nx_sel = 3'd0;
        for (int k = 0; k < 3; k++) begin
            nx_gen = 0; drive(1'b1, 1'b0, 1'b1);
            nx_gen = 1;
            for (int i = 0; i < 25; i++) drive(1'b1, 1'b0, 1'b0);
        end

        // R6: repeating words of several lengths, select aliases
        cur_tag = "R6"; nx_gen = 0; drive(1'b0, 1'b0, 1'b0);
        nx_sel = 3'd4; nx_word = 32'hA5C3_0F96; nx_len = 5'd31; nx_gen = 1;
        for (int i = 0; i < 100; i++) drive(i % 7 != 3, 1'b0, 1'b0);
        nx_gen = 0; drive(1'b0, 1'b0, 1'b0);
        nx_word = 32'h0000_0001; nx_len = 5'd0; nx_gen = 1;
        for (int i = 0; i < 12; i++) drive(1'b1, 1'b0, 1'b0);
        nx_gen = 0; drive(1'b0, 1'b0, 1'b0);
        nx_sel = 3'd6; nx_word = 32'h0000_0016; nx_len = 5'd4; nx_gen = 1;
        for (int i = 0; i < 40; i++) drive(1'b1, 1'b0, 1'b0);

        // R8: strobes on emitted bits
        cur_tag = "R8"; nx_gen = 0; drive(1'b0, 1'b0, 1'b0);
        nx_sel = 3'd1; nx_gen = 1;
        for (int i = 0; i < 60; i++) drive(1'b1, (i % 13) == 4, 1'b0);

        // R9: held requests, several strobes collapse into one flip
        cur_tag = "R9";
        drive(1'b0, 1'b1, 1'b0);
        drive(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) drive(1'b1, 1'b0, 1'b0);
        drive(1'b0, 1'b1, 1'b0);
        drive(1'b0, 1'b1, 1'b0);
        drive(1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 8; i++) drive(1'b1, 1'b0, 1'b0);

        // R10: strobes while off leave bypass data and next period clean
        cur_tag = "R10"; nx_gen = 0;
        drive(1'b0, 1'b1, 1'b0);
        drive(1'b1, 1'b1, 1'b1);
        drive(1'b1, 1'b1, 1'b0);
        drive(1'b0, 1'b1, 1'b1);
        nx_gen = 1; nx_sel = 3'd0;
        for (int i = 0; i < 20; i++) drive(1'b1, 1'b0, 1'b0);

        // R5: quasi-random stream past its first forced one, strobe on it
        cur_tag = "R5"; nx_gen = 0; drive(1'b0, 1'b0, 1'b0);
        nx_sel = 3'd3; nx_gen = 1;
        ff = qrss_first_force();
        nq = (ff < 0) ? 5000 : ((ff + 60 > 120000) ? 120000 : ff + 60);
        for (int i = 0; i < nq; i++) drive(1'b1, (i == ff), 1'b0);

        nx_gen = 0;
        repeat (3) drive(1'b0, 1'b0, 1'b0);
        repeat (3) @(posedge clk);
        #5;
        finish_run();
    end

endmodule